// File: doc/BRIEF.md
# Four-Port Cell Receive Interface

This block is the physical-layer end of an 8-bit receive handshake that hands fixed 53-byte cells to a downstream cell layer. Each of the four ports has its own buffer that holds two whole cells. A line-side write stream fills the buffers. Every beat on that stream carries a port number, a data byte and a start-of-cell mark. A port's cell-available flag rises once its buffer holds at least one complete cell.

The downstream layer draws bytes by raising the receive enable of one port. Each enabled cycle on a port that has a whole cell moves one byte. The byte, its start-of-cell mark and an odd-parity bit are registered and appear one cycle later together with `rx_vld`. Enable is the only back-pressure on the read side: lowering it pauses delivery at any byte.

The line side has no back-pressure. A cell either fits whole or is dropped, and a drop is reported on `lin_drop`. The line side must send each cell as 53 beats for one port, with the mark on the first beat. Beats for different ports may interleave.

Only one port may be enabled at a time. Once a port has been served, it stays locked until its cell-available flag falls. An enable on any other port during that time is refused, and `rx_violate` is raised.

Top module: `rx_cell_port`

## Requirements
- R1: `rx_clav[p]` is high exactly when port p holds at least one complete, not fully read cell. It rises in the cycle after the 53rd byte of a cell is written. It falls in the cycle after the last byte of the last stored cell is delivered.
- R2: A beat with `lin_sop` high starts a cell only if port p has room for all 53 bytes. Otherwise `lin_drop[p]` is high for one cycle, in the cycle after that beat, and all 53 bytes of that cell are discarded.
- R3: A cycle with exactly one bit of `rx_en` high, on a port that is allowed and has `rx_clav` high, delivers that port's next byte in write order. The byte appears on `rx_data` with `rx_vld` high in the next cycle. Enabling a port with no complete cell delivers nothing.
- R4: Whenever `rx_vld` is high, the nine bits `{rx_data, rx_par}` hold an odd number of ones.
- R5: `rx_soc` is high for exactly one clock, together with the first byte of each cell, and is low for the other 52 bytes.
- R6: A cycle with `rx_en` all low delivers nothing (`rx_vld` low next cycle). Delivery resumes at the following byte with no loss or repetition.
- R7: If more than one bit of `rx_en` is high in a cycle, no byte is delivered, and `rx_collide` is high in the next cycle.
- R8: After port p is served, an enable on another port is ignored while `rx_clav[p]` is high, and `rx_violate` is high in the next cycle. Once `rx_clav[p]` has fallen, another port may be served.
- R9: After reset, all cell-available flags, `rx_vld`, `rx_soc`, `rx_collide`, `rx_violate` and `lin_drop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lin_valid | input | 1 | Line-side beat present |
| lin_sop | input | 1 | Beat is the first byte of a cell |
| lin_port | input | 2 | Port the beat belongs to |
| lin_data | input | 8 | Line-side byte |
| lin_drop | output | 4 | Per port: the cell just started was dropped for lack of room |
| rx_en | input | 4 | Per-port receive enable from the downstream layer |
| rx_clav | output | 4 | Per-port cell-available flag |
| rx_data | output | 8 | Delivered byte |
| rx_par | output | 1 | Odd parity over rx_data |
| rx_soc | output | 1 | First byte of a cell |
| rx_vld | output | 1 | A byte is delivered this cycle |
| rx_collide | output | 1 | More than one enable was high in the previous cycle |
| rx_violate | output | 1 | Enable of a non-locked port was refused in the previous cycle |

## Verification
Every result of this block is due one clock after the stimulus that causes it. A delivered byte, its mark and its parity follow the enable that requested it. Collision and violation flags follow the offending enable. A drop flag follows the start-of-cell beat that did not fit, and a cell-available change follows the final byte written or read. The bench drives each input on the falling edge and checks the matching outputs on the next falling edge, so every check samples exactly one rising edge after its stimulus.

// File: rtl/rx_cell_pkg.sv
package rx_cell_pkg;
  localparam int unsigned CELL_LEN = 53;

  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction
endpackage

// File: rtl/rx_cell_buf.sv
module rx_cell_buf #(
  parameter int unsigned DW    = 8,
  parameter int unsigned CELL  = 53,
  parameter int unsigned NCELL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_vld,
  input  logic          wr_sop,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_first,
  output logic          clav,
  output logic          drop
);
  localparam int unsigned DEPTH = CELL * NCELL;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned UW    = AW + 1;
  localparam int unsigned CW    = $clog2(CELL);
  localparam int unsigned NW    = $clog2(NCELL + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [UW-1:0] used;
  logic [NW-1:0] cells;
  logic [CW-1:0] wcnt, ridx;
  logic          wact, room, wr_do, wr_last, pop_last;

  assign room     = (UW'(DEPTH) - used) >= UW'(CELL);
  assign wr_do    = wr_vld && (wr_sop ? room : wact);
  assign wr_last  = wr_do && !wr_sop && (wcnt == CW'(CELL - 1));
  assign pop_last = pop && (ridx == CW'(CELL - 1));

  always_ff @(posedge clk) begin
    if (wr_do) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; used <= '0; cells <= '0;
      wcnt <= '0; ridx <= '0; wact <= 1'b0; drop <= 1'b0;
    end else begin
      drop <= wr_vld && wr_sop && !room;
      if (wr_vld && wr_sop) begin
        wact <= room;
        wcnt <= room ? CW'(1) : '0;
      end else if (wr_last) begin
        wact <= 1'b0;
        wcnt <= '0;
      end else if (wr_do) begin
        wcnt <= wcnt + CW'(1);
      end
      if (wr_do) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop) begin
        rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
        ridx <= pop_last ? '0 : ridx + CW'(1);
      end
      case ({wr_do, pop})
        2'b10:   used <= used + UW'(1);
        2'b01:   used <= used - UW'(1);
        default: used <= used;
      endcase
      case ({wr_last, pop_last})
        2'b10:   cells <= cells + NW'(1);
        2'b01:   cells <= cells - NW'(1);
        default: cells <= cells;
      endcase
    end
  end

  assign rd_data  = mem[rptr];
  assign rd_first = (ridx == '0);
  assign clav     = (cells != '0);

  assert_cells_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cells <= NW'(NCELL));
  assert_pop_needs_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cells != '0);
endmodule

// File: rtl/rx_cell_arb.sv
module rx_cell_arb #(
  parameter int unsigned NP = 4,
  localparam int unsigned PW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] en,
  input  logic [NP-1:0] clav,
  output logic          pop,
  output logic [PW-1:0] sel,
  output logic          collide,
  output logic          violate
);
  logic          lock_vld;
  logic [PW-1:0] lock_port;
  logic          single, blocked, go;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NP; i++) begin
      if (en[i]) sel = PW'(i);
    end
  end

  assign single  = ($countones(en) == 1);
  assign collide = ($countones(en) > 1);
  assign blocked = lock_vld && (sel != lock_port) && clav[lock_port];
  assign violate = single && blocked;
  assign go      = single && !blocked;
  assign pop     = go && clav[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_vld  <= 1'b0;
      lock_port <= '0;
    end else if (go) begin
      lock_vld  <= 1'b1;
      lock_port <= sel;
    end
  end

  assert_lock_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_vld && clav[lock_port] && !$past(go) && $past(rst_n) && $past(lock_vld))
      |-> $stable(lock_port));
endmodule

// File: rtl/rx_cell_out.sv
module rx_cell_out #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic [DW-1:0] data,
  input  logic          first,
  input  logic          collide,
  input  logic          violate,
  output logic [DW-1:0] rx_data,
  output logic          rx_par,
  output logic          rx_soc,
  output logic          rx_vld,
  output logic          rx_collide,
  output logic          rx_violate
);
  import rx_cell_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0; rx_par <= 1'b1; rx_soc <= 1'b0;
      rx_vld <= 1'b0; rx_collide <= 1'b0; rx_violate <= 1'b0;
    end else begin
      rx_vld     <= pop;
      rx_soc     <= pop && first;
      rx_collide <= collide;
      rx_violate <= violate;
      if (pop) begin
        rx_data <= data;
        rx_par  <= odd_par(data);
      end
    end
  end

  assert_odd_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |-> ^{rx_data, rx_par});
  assert_soc_with_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_soc |-> rx_vld);
  assert_collide_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_collide |-> !rx_vld);
endmodule

// File: rtl/rx_cell_port.sv
module rx_cell_port #(
  parameter int unsigned NP    = 4,
  parameter int unsigned DW    = 8,
  parameter int unsigned CELL  = rx_cell_pkg::CELL_LEN,
  parameter int unsigned NCELL = 2,
  localparam int unsigned PW   = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lin_valid,
  input  logic          lin_sop,
  input  logic [PW-1:0] lin_port,
  input  logic [DW-1:0] lin_data,
  output logic [NP-1:0] lin_drop,
  input  logic [NP-1:0] rx_en,
  output logic [NP-1:0] rx_clav,
  output logic [DW-1:0] rx_data,
  output logic          rx_par,
  output logic          rx_soc,
  output logic          rx_vld,
  output logic          rx_collide,
  output logic          rx_violate
);
  logic          pop, collide, violate;
  logic [PW-1:0] sel;
  logic [DW-1:0] head  [NP];
  logic [NP-1:0] first;

  rx_cell_arb #(.NP(NP)) u_arb (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .clav(rx_clav),
    .pop(pop), .sel(sel), .collide(collide), .violate(violate)
  );

  for (genvar g = 0; g < NP; g++) begin : g_port
    rx_cell_buf #(.DW(DW), .CELL(CELL), .NCELL(NCELL)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_vld(lin_valid && (lin_port == PW'(g))),
      .wr_sop(lin_sop), .wr_data(lin_data),
      .pop(pop && (sel == PW'(g))),
      .rd_data(head[g]), .rd_first(first[g]),
      .clav(rx_clav[g]), .drop(lin_drop[g])
    );
  end

  rx_cell_out #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .pop(pop), .data(head[sel]), .first(first[sel]),
    .collide(collide), .violate(violate),
    .rx_data(rx_data), .rx_par(rx_par), .rx_soc(rx_soc), .rx_vld(rx_vld),
    .rx_collide(rx_collide), .rx_violate(rx_violate)
  );
endmodule

// File: tb/rx_cell_port_bench.sv
module rx_cell_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lin_valid = 1'b0, lin_sop = 1'b0;
  logic [1:0] lin_port = '0;
  logic [7:0] lin_data = '0;
  logic [3:0] lin_drop, rx_en = '0, rx_clav;
  logic [7:0] rx_data;
  logic       rx_par, rx_soc, rx_vld, rx_collide, rx_violate;
  int checks = 0, errors = 0;
  bit done = 0;
  logic last_drop;

  always #5 clk = ~clk;

  rx_cell_port u_rx_cell_port (
    .clk(clk), .rst_n(rst_n), .lin_valid(lin_valid), .lin_sop(lin_sop),
    .lin_port(lin_port), .lin_data(lin_data), .lin_drop(lin_drop),
    .rx_en(rx_en), .rx_clav(rx_clav), .rx_data(rx_data), .rx_par(rx_par),
    .rx_soc(rx_soc), .rx_vld(rx_vld), .rx_collide(rx_collide),
    .rx_violate(rx_violate)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // 53 beats for one port; records lin_drop seen one cycle after the sop beat
  task automatic send_cell(input int p, input int base);
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      if (i == 1) last_drop = lin_drop[p];
      lin_valid = 1'b1; lin_sop = (i == 0); lin_port = 2'(p);
      lin_data = 8'(base + i);
    end
    @(negedge clk);
    lin_valid = 1'b0; lin_sop = 1'b0;
  endtask

  // enable port p for bytes lo..hi; each checked one cycle after its enable
  task automatic read_bytes(input int p, input int base, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      rx_en = 4'(1 << p);
      @(negedge clk);
      chk(rx_vld == 1'b1, "R3", "vld", rx_vld, 1);
      chk(rx_data == 8'(base + i), "R3", "data", rx_data, 8'(base + i));
      chk(^{rx_data, rx_par} == 1'b1, "R4", "parity", rx_par, ~^rx_data);
      chk(rx_soc == (i == 0), "R5", "soc", rx_soc, (i == 0));
    end
    rx_en = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rx_clav == 4'h0, "R9", "clav", rx_clav, 0);
    chk(rx_vld == 1'b0 && rx_soc == 1'b0, "R9", "vld/soc", {rx_vld, rx_soc}, 0);
    chk(rx_collide == 1'b0 && rx_violate == 1'b0, "R9", "flags", {rx_collide, rx_violate}, 0);
    chk(lin_drop == 4'h0, "R9", "drop", lin_drop, 0);
  endtask

  task automatic t_basic;
    send_cell(0, 8'h10);
    chk(last_drop == 1'b0, "R2", "no drop", last_drop, 0);
    chk(rx_clav == 4'b0001, "R1", "clav after write", rx_clav, 4'b0001);
    read_bytes(0, 8'h10, 0, 52);
    chk(rx_clav == 4'b0000, "R1", "clav after drain", rx_clav, 0);
  endtask

  task automatic t_pause;
    send_cell(1, 8'h33);
    read_bytes(1, 8'h33, 0, 19);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rx_vld == 1'b0, "R6", "paused vld", rx_vld, 0);
    end
    read_bytes(1, 8'h33, 20, 52);
    chk(rx_clav[1] == 1'b0, "R6", "drained", rx_clav[1], 0);
  endtask

  task automatic t_collide;
    send_cell(2, 8'h50);
    rx_en = 4'b0101;
    @(negedge clk);
    rx_en = '0;
    chk(rx_vld == 1'b0, "R7", "no data on collision", rx_vld, 0);
    chk(rx_collide == 1'b1, "R7", "collide flag", rx_collide, 1);
    read_bytes(2, 8'h50, 0, 52);
    chk(rx_collide == 1'b0, "R7", "collide cleared", rx_collide, 0);
  endtask

  task automatic t_lock;
    send_cell(0, 8'h20);
    send_cell(3, 8'h60);
    read_bytes(0, 8'h20, 0, 4);
    rx_en = 4'b1000;
    @(negedge clk);
    rx_en = '0;
    chk(rx_vld == 1'b0, "R8", "refused port vld", rx_vld, 0);
    chk(rx_violate == 1'b1, "R8", "violate flag", rx_violate, 1);
    read_bytes(0, 8'h20, 5, 52);
    chk(rx_violate == 1'b0, "R8", "violate cleared", rx_violate, 0);
    read_bytes(3, 8'h60, 0, 52);
    chk(rx_clav == 4'b0000, "R8", "all drained", rx_clav, 0);
  endtask

  task automatic t_overflow;
    send_cell(1, 8'h40);
    chk(last_drop == 1'b0, "R2", "first fits", last_drop, 0);
    send_cell(1, 8'h80);
    chk(last_drop == 1'b0, "R2", "second fits", last_drop, 0);
    send_cell(1, 8'hC0);
    chk(last_drop == 1'b1, "R2", "third dropped", last_drop, 1);
    read_bytes(1, 8'h40, 0, 52);
    chk(rx_clav[1] == 1'b1, "R1", "one cell left", rx_clav[1], 1);
    read_bytes(1, 8'h80, 0, 52);
    chk(rx_clav[1] == 1'b0, "R2", "dropped cell absent", rx_clav[1], 0);
  endtask

  task automatic t_empty;
    rx_en = 4'b0100;
    @(negedge clk);
    rx_en = '0;
    chk(rx_vld == 1'b0, "R3", "empty port no data", rx_vld, 0);
    chk(rx_violate == 1'b0, "R8", "no lock held", rx_violate, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_pause();
    t_collide();
    t_lock();
    t_overflow();
    t_empty();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule